// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block is a small bank of chip control registers reached through a single-cycle register port. Reads are always served combinationally. Writes to the protected registers take effect only after a global two-key unlock has been completed on a pair of dedicated key registers. The device enable word needs one more condition: a separate lock register must hold a fixed key value.

The bank holds several kinds of register:
- a read-only status word that carries a 4-bit silicon revision and a field of strap inputs;
- a device control word built from equal 2-bit fields, one for each device;
- a configuration word in which a chosen set of bits can be written only once between resets;
- an Ethernet reset word in which only the bits of a parameter mask exist.

Blocked writes finish on the bus like any other write and leave every register as it was.

Top module: `cfg_keybank`

## Requirements
- R1: After reset the bank is locked, the key readback (word 2) reads 0, and the lock word, device control word, write-once word and Ethernet reset word all read 0.
- R2: Writing 0x83E70B13 to word 1 and then 0x95A4F1E0 to word 2 unlocks the bank. Bit 0 of word 2 reads 1 while the bank is unlocked. Writing the first key again while unlocked keeps the bank unlocked.
- R3: The bank stays locked in each of these cases: a wrong value is written to word 1; the second key is written with no first key before it; a wrong value is written to word 2 after the first key. A wrong value written to word 1 while unlocked locks the bank again.
- R4: While the bank is locked, writes to words 3 to 6 are ignored. Reads of every word are always served.
- R5: Device control (word 4) accepts a write only while the bank is unlocked and lock word 3 holds 0x0F0A0B00. Word 3 itself accepts writes only while the bank is unlocked.
- R6: Word 4 packs NDEV = 12 fields of 2 bits, with device i at bits [2i+1:2i]. The output dev_en[i] is 1 exactly when that field holds the enable code 1. Bits 24 to 31 read 0.
- R7: Devices flagged in NODIS_MASK (default: device 11) cannot be disabled. A write that places the disable code 0 in such a field leaves the field unchanged. Any other code is stored.
- R8: Word 5 has write-once bits selected by WO_MASK (default 0x0000FF00). The first accepted write stores all 32 bits. Later accepted writes change only the bits outside the mask. Only reset makes the masked bits writable again.
- R9: Word 0 is read-only. It reads {REV, strap_stat}, so the revision sits at bits [31:28], REV defaults to 4'h3, and strap_stat fills bits [27:0]. Writes to word 0 have no effect.
- R10: Word 6 stores only the bits of ETH_RST_MASK (default 0x00040000). The other bits read 0. The stored value drives eth_rst.
- R11: Word 1 and word 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| strap_stat | input | 28 | Device status straps shown in word 0 |
| dev_en | output | 12 | Per-device enable decoded from word 4 |
| wo_cfg | output | 32 | Write-once configuration word |
| eth_rst | output | 32 | Ethernet reset bits, masked |

## Verification
Faults in the key sequencer have only one place to show at the ports: bit 0 of word 2. The first write cycle after the faulty transition changes that bit, and it reads back on the very next cycle. A stale lock key or a wrong write-once flag stays hidden until the next write to word 4 or word 5. After that write, the word reads back differently and dev_en or wo_cfg differs from the bench model one cycle later. The bench therefore follows every write with a readback. It also sweeps every device field through every code, so that a field-decoding fault shows up within a single write.

// File: rtl/cfg_keybank_pkg.sv
package cfg_keybank_pkg;
  localparam logic [31:0] KICK_KEY_A = 32'h83E7_0B13;
  localparam logic [31:0] KICK_KEY_B = 32'h95A4_F1E0;
  localparam logic [31:0] LOCK_KEY   = 32'h0F0A_0B00;

  typedef enum logic [1:0] {KS_LOCKED, KS_HALF, KS_OPEN} kick_state_e;

  // Next state of the global unlock sequencer
  function automatic kick_state_e kick_next(kick_state_e s, logic wr_a, logic wr_b,
                                            logic [31:0] d);
    kick_state_e n;
    n = s;
    if (wr_a) begin
      if (d != KICK_KEY_A)   n = KS_LOCKED;
      else if (s != KS_OPEN) n = KS_HALF;
    end else if (wr_b && s == KS_HALF) begin
      n = (d == KICK_KEY_B) ? KS_OPEN : KS_LOCKED;
    end
    return n;
  endfunction

  // Write-once merge: frozen bits keep their value once a write has landed
  function automatic logic [31:0] wo_merge(logic [31:0] cur, logic [31:0] d,
                                           logic [31:0] mask, logic done);
    logic [31:0] frz;
    frz = mask & {32{done}};
    return (cur & frz) | (d & ~frz);
  endfunction
endpackage

// File: rtl/cfg_kick_seq.sv
module cfg_kick_seq
  import cfg_keybank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_a,
  input  logic        wr_b,
  input  logic [31:0] wdata,
  output logic        open_o
);
  kick_state_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= KS_LOCKED;
    else        st <= kick_next(st, wr_a, wr_b, wdata);
  end

  assign open_o = (st == KS_OPEN);
endmodule

// File: rtl/cfg_dev_field.sv
module cfg_dev_field #(
  parameter int FW       = 2,
  parameter int EN_CODE  = 1,
  parameter int DIS_CODE = 0,
  parameter bit NODIS    = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [FW-1:0] wfield,
  output logic [FW-1:0] q,
  output logic          en
);
  localparam logic [FW-1:0] ENC = FW'(EN_CODE);
  localparam logic [FW-1:0] DSC = FW'(DIS_CODE);

  function automatic logic [FW-1:0] field_next(logic [FW-1:0] cur, logic [FW-1:0] d);
    return (NODIS && d == DSC) ? cur : d;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= DSC;
    else if (wr) q <= field_next(q, wfield);
  end

  assign en = (q == ENC);
endmodule

// File: rtl/cfg_wo_reg.sv
module cfg_wo_reg
  import cfg_keybank_pkg::*;
#(
  parameter logic [31:0] WO_MASK = 32'h0000_FF00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] d,
  output logic [31:0] q,
  output logic        done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q    <= '0;
      done <= 1'b0;
    end else if (wr) begin
      q    <= wo_merge(q, d, WO_MASK, done);
      done <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_keybank.sv
module cfg_keybank
  import cfg_keybank_pkg::*;
#(
  parameter int          ADDR_W       = 3,
  parameter int          NDEV         = 12,
  parameter int          FW           = 2,
  parameter int          EN_CODE      = 1,
  parameter int          DIS_CODE     = 0,
  parameter logic [11:0] NODIS_MASK   = 12'h800,
  parameter logic [31:0] WO_MASK      = 32'h0000_FF00,
  parameter logic [31:0] ETH_RST_MASK = 32'h0004_0000,
  parameter logic [3:0]  REV          = 4'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [27:0]       strap_stat,
  output logic [NDEV-1:0]   dev_en,
  output logic [31:0]       wo_cfg,
  output logic [31:0]       eth_rst
);
  localparam int CTL_W = NDEV * FW;
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_KICKA = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_KICKB = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_LOCK  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_WO    = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_ETH   = ADDR_W'(6);

  // Named internal events for the checker
  logic             kick_open;
  logic             wr_ok;
  logic             wr_blocked;
  logic             ctl_wr;
  logic             wo_done;
  logic [31:0]      lock_q;
  logic [CTL_W-1:0] ctl_q;
  logic [31:0]      ctl_rd;
  logic [31:0]      wo_q;
  logic [31:0]      eth_q;

  cfg_kick_seq u_kick (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_a   (bus_we && bus_addr == A_KICKA),
    .wr_b   (bus_we && bus_addr == A_KICKB),
    .wdata  (bus_wdata),
    .open_o (kick_open)
  );

  assign wr_ok      = bus_we && kick_open;
  assign wr_blocked = bus_we && !kick_open && bus_addr != A_KICKA && bus_addr != A_KICKB;
  assign ctl_wr     = wr_ok && bus_addr == A_CTL && lock_q == LOCK_KEY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= '0;
      eth_q  <= '0;
    end else if (wr_ok) begin
      if (bus_addr == A_LOCK) lock_q <= bus_wdata;
      if (bus_addr == A_ETH)  eth_q  <= bus_wdata & ETH_RST_MASK;
    end
  end

  for (genvar i = 0; i < NDEV; i++) begin : g_dev
    cfg_dev_field #(
      .FW(FW), .EN_CODE(EN_CODE), .DIS_CODE(DIS_CODE), .NODIS(NODIS_MASK[i])
    ) u_fld (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (ctl_wr),
      .wfield (bus_wdata[i*FW +: FW]),
      .q      (ctl_q[i*FW +: FW]),
      .en     (dev_en[i])
    );
  end

  cfg_wo_reg #(.WO_MASK(WO_MASK)) u_wo (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_ok && bus_addr == A_WO),
    .d     (bus_wdata),
    .q     (wo_q),
    .done  (wo_done)
  );

  always_comb begin
    ctl_rd = '0;
    ctl_rd[CTL_W-1:0] = ctl_q;
  end

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = {REV, strap_stat};
      A_KICKB: bus_rdata = {31'b0, kick_open};
      A_LOCK:  bus_rdata = lock_q;
      A_CTL:   bus_rdata = ctl_rd;
      A_WO:    bus_rdata = wo_q;
      A_ETH:   bus_rdata = eth_q;
      default: bus_rdata = '0;
    endcase
  end

  assign wo_cfg  = wo_q;
  assign eth_rst = eth_q;
endmodule

// File: rtl/cfg_keybank_chk.sv
module cfg_keybank_chk
  import cfg_keybank_pkg::*;
#(
  parameter int          ADDR_W       = 3,
  parameter int          CTL_W        = 24,
  parameter logic [31:0] WO_MASK      = 32'h0000_FF00,
  parameter logic [31:0] ETH_RST_MASK = 32'h0004_0000,
  parameter logic [3:0]  REV          = 4'h3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              kick_open,
  input logic              wr_blocked,
  input logic [31:0]       lock_q,
  input logic [CTL_W-1:0]  ctl_q,
  input logic [31:0]       wo_q,
  input logic              wo_done,
  input logic [31:0]       eth_rst
);
  p_open_needs_key_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kick_open) |-> $past(bus_we && bus_addr == ADDR_W'(2) && bus_wdata == KICK_KEY_B));

  p_bad_key_a_relocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(1) && bus_wdata != KICK_KEY_A) |=> !kick_open);

  p_blocked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> ($stable(lock_q) && $stable(ctl_q) && $stable(wo_q) && $stable(eth_rst)));

  p_lock_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(4) && lock_q != LOCK_KEY) |=> $stable(ctl_q));

  p_wo_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wo_done |=> ($stable(wo_q & WO_MASK) && wo_done));

  p_rev_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(0)) |-> (bus_rdata[31:28] == REV));

  p_eth_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eth_rst & ~ETH_RST_MASK) == 32'b0);

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(7) || bus_addr == ADDR_W'(1)) |-> (bus_rdata == 32'b0));
endmodule

bind cfg_keybank cfg_keybank_chk #(
  .ADDR_W(ADDR_W), .CTL_W(CTL_W), .WO_MASK(WO_MASK),
  .ETH_RST_MASK(ETH_RST_MASK), .REV(REV)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .kick_open  (kick_open),
  .wr_blocked (wr_blocked),
  .lock_q     (lock_q),
  .ctl_q      (ctl_q),
  .wo_q       (wo_q),
  .wo_done    (wo_done),
  .eth_rst    (eth_rst)
);

// File: tb/cfg_keybank_tb.sv
module cfg_keybank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [27:0] strap_stat = 28'h5A5_1234;
  logic [11:0] dev_en;
  logic [31:0] wo_cfg;
  logic [31:0] eth_rst;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  localparam logic [31:0] KA = 32'h83E7_0B13;
  localparam logic [31:0] KB = 32'h95A4_F1E0;
  localparam logic [31:0] LK = 32'h0F0A_0B00;

  logic [23:0] m_ctl;
  logic [31:0] m_wo;

  always #4 clk = ~clk;

  cfg_keybank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .strap_stat(strap_stat),
    .dev_en(dev_en), .wo_cfg(wo_cfg), .eth_rst(eth_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Bench model of a device-control write: device 11 ignores code 0
  function automatic logic [23:0] ctl_model(logic [23:0] cur, logic [23:0] d);
    logic [23:0] r;
    r = d;
    if (d[23:22] == 2'd0) r[23:22] = cur[23:22];
    return r;
  endfunction

  function automatic logic [11:0] en_model(logic [23:0] c);
    logic [11:0] e;
    for (int i = 0; i < 12; i++) e[i] = ((c >> (2 * i)) & 24'h3) == 24'h1;
    return e;
  endfunction

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_ctl = '0;

    // R1 reset state
    for (int a = 2; a <= 6; a++) begin
      rd(3'(a), v); chk("R1 reset readback", v, 32'h0);
    end
    chk("R1 dev_en after reset", {20'b0, dev_en}, 32'h0);

    // R9 status word and write ignored
    rd(3'd0, v); chk("R9 status word", v, {4'h3, strap_stat});
    // R11 unmapped / key word reads
    rd(3'd7, v); chk("R11 word 7 zero", v, 32'h0);
    rd(3'd1, v); chk("R11 word 1 zero", v, 32'h0);

    // R4 locked writes ignored
    wr(3'd3, LK); wr(3'd4, 24'h555555); wr(3'd5, 32'hFFFF_FFFF); wr(3'd6, 32'hFFFF_FFFF);
    for (int a = 3; a <= 6; a++) begin
      rd(3'(a), v); chk("R4 locked write ignored", v, 32'h0);
    end

    // R3 wrong sequences
    wr(3'd2, KB);            rd(3'd2, v); chk("R3 key B first", v, 32'h0);
    wr(3'd1, 32'h1234_5678); wr(3'd2, KB); rd(3'd2, v); chk("R3 bad key A", v, 32'h0);
    wr(3'd1, KA); wr(3'd2, 32'hDEAD_BEEF); rd(3'd2, v); chk("R3 bad key B", v, 32'h0);
    wr(3'd2, KB);            rd(3'd2, v); chk("R3 key B after bad B", v, 32'h0);

    // R2 correct sequence
    wr(3'd1, KA); rd(3'd2, v); chk("R2 half sequence still locked", v, 32'h0);
    wr(3'd2, KB); rd(3'd2, v); chk("R2 unlocked", v, 32'h1);
    wr(3'd1, KA); rd(3'd2, v); chk("R2 key A again stays unlocked", v, 32'h1);

    // R9 write to status ignored
    wr(3'd0, 32'h0); rd(3'd0, v); chk("R9 status write ignored", v, {4'h3, strap_stat});

    // R5 device control needs lock key
    wr(3'd3, 32'h0F0A_0B01); wr(3'd4, 24'h555555);
    rd(3'd4, v); chk("R5 wrong lock value blocks", v, 32'h0);
    wr(3'd3, LK); rd(3'd3, v); chk("R5 lock word stored", v, LK);

    // R6/R7 sweep every device through every code
    for (int i = 0; i < 12; i++) begin
      for (int c = 0; c < 4; c++) begin
        logic [23:0] nv;
        nv = m_ctl;
        nv[2*i +: 2] = 2'(c);
        wr(3'd4, {8'hFF, nv});
        m_ctl = ctl_model(m_ctl, nv);
        rd(3'd4, v); chk("R6 field sweep readback", v, {8'h0, m_ctl});
        chk("R6 dev_en decode", {20'b0, dev_en}, {20'b0, en_model(m_ctl)});
      end
    end
    // R7 explicit: device 11 enabled, then all-zero write
    wr(3'd4, 24'h400000); m_ctl = ctl_model(m_ctl, 24'h400000);
    wr(3'd4, 24'h000000); m_ctl = ctl_model(m_ctl, 24'h000000);
    rd(3'd4, v); chk("R7 device 11 not disabled", v, 32'h0040_0000);
    chk("R7 dev_en[11] kept", {31'b0, dev_en[11]}, 32'h1);

    // R8 write-once bits
    wr(3'd5, 32'hA5A5_C3C3); m_wo = 32'hA5A5_C3C3;
    rd(3'd5, v); chk("R8 first write", v, m_wo);
    wr(3'd5, 32'h0000_0000); m_wo = (m_wo & 32'h0000_FF00);
    rd(3'd5, v); chk("R8 masked bits frozen", v, m_wo);
    wr(3'd5, 32'hFFFF_FFFF); m_wo = m_wo | 32'hFFFF_00FF;
    rd(3'd5, v); chk("R8 free bits writable", v, m_wo);
    chk("R8 wo_cfg port", wo_cfg, m_wo);

    // R10 ethernet reset mask
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, v); chk("R10 masked readback", v, 32'h0004_0000);
    chk("R10 eth_rst port", eth_rst, 32'h0004_0000);

    // R3 relock, then R4 blocked writes
    wr(3'd1, 32'h0);
    rd(3'd2, v); chk("R3 relock by bad key A", v, 32'h0);
    wr(3'd6, 32'h0); rd(3'd6, v); chk("R4 blocked eth write", v, 32'h0004_0000);
    wr(3'd4, 24'h0); rd(3'd4, v); chk("R4 blocked ctl write", v, {8'h0, m_ctl});

    // R8 reset clears write-once flag
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    rd(3'd5, v); chk("R1 write-once cleared by reset", v, 32'h0);
    wr(3'd1, KA); wr(3'd2, KB); wr(3'd5, 32'h0000_1200);
    rd(3'd5, v); chk("R8 writable again after reset", v, 32'h0000_1200);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule